// File: doc/BRIEF.md
# Per-Lane Link Synchronization Controller

This block tracks word-level link state for a single lane of a four-lane bonded receiver. Every clock it is given one received word's indications: whether the word was the K28.5 comma, whether the 8B/10B decoder flagged it, whether this lane's clock recovery has lost lock, whether any lane of the group has lost lock, and whether the lanes as a group are ready. It steps through four states: idle (no sync), acquiring, aligning and locked. It reports each state as a 3-bit status code {err, eof, kflag} and passes the lane's loss-of-lock flag straight through.

In bonded mode a lane enters the locked state only when the external group-ready signal (the AND of the four lanes' `ready_o`) is high and the word is clean data. All lanes therefore lock on the same word. In independent mode the group-ready and group-unlock inputs are ignored. While the lane is locked, an error monitor watches for a run of decode errors or for a majority error rate within a fixed-size word block, and either one drops the lane back to idle. A reference-clock-good input that stays low long enough also forces idle.

Top module: `lane_sync_ctrl`

## Requirements
- R1: While and after reset the lane is idle: status_o = 3'b000 and ready_o = 0.
- R2: A comma word while idle moves the lane to acquiring, which is reported as status_o = 3'b011.
- R3: While acquiring, the lane moves to aligning on the fourth consecutive comma (the comma that left idle counts as the first). A non-comma word resets the count to zero and the lane stays in acquiring.
- R4: While aligning, ready_o = 1. status_o = 3'b111 when no_skew_i = 0, and 3'b011 when no_skew_i = 1 (this lane needed no delay, so the 111 code is never shown).
- R5: While aligning, a word that is neither a comma nor a decode error moves the lane to locked (status_o = 3'b010). In bonded mode (bond_mode_i = 1) this also requires all_ready_i = 1. In independent mode all_ready_i is ignored.
- R6: While locked, five consecutive decode errors return the lane to idle after the fifth. Four errors followed by a clean word do not.
- R7: While locked, non-comma words are counted in blocks of 16. If more than 8 of the 16 are decode errors, the lane returns to idle after the sixteenth word. Exactly 8 errors keep it locked, and a new block then starts.
- R8: A comma word while locked clears the run count and the block counts. So four errors, a comma and four more errors keep the lane locked.
- R9: pll_unlock_i = 1 returns the lane to idle from any state. In bonded mode group_unlock_i = 1 returns a locked lane to idle. In independent mode group_unlock_i has no effect.
- R10: ref_ok_i held low for 16 consecutive cycles returns the lane to idle after the sixteenth. A run of 15 low cycles has no effect.
- R11: lol_o follows pll_unlock_i in the same cycle. In independent mode pll_unlock_i = 1 forces status_o = 3'b101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bond_mode_i | input | 1 | 1 = bonded four-lane operation, 0 = independent |
| ref_ok_i | input | 1 | Reference clock good; low for 16 cycles forces idle |
| pll_unlock_i | input | 1 | This lane's clock recovery has lost lock |
| group_unlock_i | input | 1 | Some lane in the group has lost lock |
| comma_i | input | 1 | Current word is a K28.5 comma |
| dec_err_i | input | 1 | Current word failed 8B/10B decoding |
| no_skew_i | input | 1 | Deskew logic applied no delay to this lane |
| all_ready_i | input | 1 | All four lanes report ready |
| status_o | output | 3 | Status code {err, eof, kflag} |
| lol_o | output | 1 | Loss-of-lock indication |
| ready_o | output | 1 | Lane is aligning and waiting for the group |

## Verification
The comma runs include sequences broken by a data word after two and after three commas. These separate a count that restarts from one that only pauses. The error patterns stay locked with four consecutive errors, and with exactly eight errors spread over a block, but drop with nine errors in a block that never contains five in a row. This tells the run-length rule apart from the rate rule and puts both limits at their edges. The reference-clock input is held low for 15 cycles, released, and then held low for 16 cycles, which shows that the hold counter restarts when the input returns high. The unlock and group-ready inputs are applied in both bonded and independent mode, to show which mode each of them affects.

// File: rtl/lsync_pkg.sv
package lsync_pkg;

  typedef enum logic [1:0] {
    ST_NOSYNC = 2'd0,
    ST_ACQ    = 2'd1,
    ST_RESYNC = 2'd2,
    ST_INSYNC = 2'd3
  } lsync_state_e;

  localparam logic [2:0] STAT_IDLE   = 3'b000;
  localparam logic [2:0] STAT_COMMA  = 3'b011;
  localparam logic [2:0] STAT_ALIGN  = 3'b111;
  localparam logic [2:0] STAT_LOCKED = 3'b010;
  localparam logic [2:0] STAT_UNLOCK = 3'b101;

endpackage

// File: rtl/lsync_hold_det.sv
module lsync_hold_det #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ok_i,
  output logic force_o
);
  localparam int CW = (HOLD > 2) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] low_q, low_d;
  logic          at_last;

  assign at_last = (low_q == LAST);

  always_comb begin
    if (ref_ok_i)     low_d = '0;
    else if (at_last) low_d = low_q;
    else              low_d = low_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= '0;
    else        low_q <= low_d;
  end

  assign force_o = !ref_ok_i && at_last;

  // R10: the force can only begin after a low cycle on the reference input
  p_force_after_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_o) |-> $past(!ref_ok_i));

endmodule

// File: rtl/lsync_err_mon.sv
module lsync_err_mon #(
  parameter int CONSEC_LIM = 5,
  parameter int BLOCK_LEN  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic comma_i,
  input  logic err_i,
  output logic drop_o
);
  localparam int RW = $clog2(CONSEC_LIM);
  localparam int BW = $clog2(BLOCK_LEN + 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(CONSEC_LIM - 1);
  localparam logic [BW-1:0] BLK_LAST = BW'(BLOCK_LEN - 1);
  localparam logic [BW-1:0] BLK_HALF = BW'(BLOCK_LEN / 2);

  logic [RW-1:0] run_q, run_d;
  logic [BW-1:0] words_q, words_d, errs_q, errs_d, errs_inc;
  logic          clr, blk_end, hit_run, hit_rate;

  always_comb begin
    clr      = !en_i || comma_i;
    errs_inc = errs_q + BW'(err_i);
    blk_end  = (words_q == BLK_LAST);
    hit_run  = err_i && (run_q == RUN_LAST);
    hit_rate = blk_end && (errs_inc > BLK_HALF);
    drop_o   = !clr && (hit_run || hit_rate);

    if (clr || blk_end) begin
      words_d = '0;
      errs_d  = '0;
    end else begin
      words_d = words_q + BW'(1);
      errs_d  = errs_inc;
    end

    if (clr || !err_i || hit_run) run_d = '0;
    else                          run_d = run_q + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      words_q <= '0;
      errs_q  <= '0;
    end else begin
      run_q   <= run_d;
      words_q <= words_d;
      errs_q  <= errs_d;
    end
  end

  // R7: the word position never runs past the block length
  p_block_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    words_q < BW'(BLOCK_LEN));

  // R8: a comma leaves every counter at zero
  p_comma_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    comma_i |=> (run_q == '0) && (words_q == '0) && (errs_q == '0));

  // R6: the error run stays below the limit
  p_run_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < RW'(CONSEC_LIM));

endmodule

// File: rtl/lsync_stat_enc.sv
module lsync_stat_enc
  import lsync_pkg::*;
(
  input  lsync_state_e state_i,
  input  logic         bond_mode_i,
  input  logic         pll_unlock_i,
  input  logic         no_skew_i,
  output logic [2:0]   status_o
);
  always_comb begin
    if (!bond_mode_i && pll_unlock_i) begin
      status_o = STAT_UNLOCK;
    end else begin
      unique case (state_i)
        ST_NOSYNC: status_o = STAT_IDLE;
        ST_ACQ:    status_o = STAT_COMMA;
        ST_RESYNC: status_o = no_skew_i ? STAT_COMMA : STAT_ALIGN;
        default:   status_o = STAT_LOCKED;
      endcase
    end
  end
endmodule

// File: rtl/lane_sync_ctrl.sv
module lane_sync_ctrl
  import lsync_pkg::*;
#(
  parameter int ACQ_COMMAS  = 4,
  parameter int CONSEC_LIM  = 5,
  parameter int BLOCK_LEN   = 16,
  parameter int HOLD_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bond_mode_i,
  input  logic       ref_ok_i,
  input  logic       pll_unlock_i,
  input  logic       group_unlock_i,
  input  logic       comma_i,
  input  logic       dec_err_i,
  input  logic       no_skew_i,
  input  logic       all_ready_i,
  output logic [2:0] status_o,
  output logic       lol_o,
  output logic       ready_o
);
  localparam int AW = $clog2(ACQ_COMMAS);
  localparam logic [AW-1:0] ACQ_LAST = AW'(ACQ_COMMAS - 1);

  lsync_state_e  st_q, st_d;
  logic [AW-1:0] acq_q, acq_d;
  logic          force_idle, drop, clean_word, group_ok;

  lsync_hold_det #(.HOLD(HOLD_CYCLES)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_ok_i (ref_ok_i),
    .force_o  (force_idle)
  );

  lsync_err_mon #(.CONSEC_LIM(CONSEC_LIM), .BLOCK_LEN(BLOCK_LEN)) u_errmon (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (st_q == ST_INSYNC),
    .comma_i (comma_i),
    .err_i   (dec_err_i),
    .drop_o  (drop)
  );

  lsync_stat_enc u_enc (
    .state_i      (st_q),
    .bond_mode_i  (bond_mode_i),
    .pll_unlock_i (pll_unlock_i),
    .no_skew_i    (no_skew_i),
    .status_o     (status_o)
  );

  assign clean_word = !comma_i && !dec_err_i;
  assign group_ok   = all_ready_i || !bond_mode_i;

  always_comb begin
    st_d  = st_q;
    acq_d = acq_q;
    if (force_idle || pll_unlock_i) begin
      st_d  = ST_NOSYNC;
      acq_d = '0;
    end else begin
      unique case (st_q)
        ST_NOSYNC: if (comma_i) begin
          st_d  = ST_ACQ;
          acq_d = AW'(1);
        end
        ST_ACQ: begin
          if (!comma_i) begin
            acq_d = '0;
          end else if (acq_q == ACQ_LAST) begin
            st_d  = ST_RESYNC;
            acq_d = '0;
          end else begin
            acq_d = acq_q + AW'(1);
          end
        end
        ST_RESYNC: if (clean_word && group_ok) st_d = ST_INSYNC;
        default:   if (drop || (bond_mode_i && group_unlock_i)) st_d = ST_NOSYNC;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_NOSYNC;
      acq_q <= '0;
    end else begin
      st_q  <= st_d;
      acq_q <= acq_d;
    end
  end

  assign ready_o = (st_q == ST_RESYNC);
  assign lol_o   = pll_unlock_i;

  // R2: a comma seen while idle starts acquisition
  p_comma_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_NOSYNC && comma_i && !pll_unlock_i && !force_idle) |=> st_q == ST_ACQ);

  // R5: locked is only ever entered from aligning
  p_lock_from_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_INSYNC && $past(st_q) != ST_INSYNC) |-> $past(st_q) == ST_RESYNC);

  // R9: own loss of lock always lands in idle
  p_unlock_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pll_unlock_i |=> st_q == ST_NOSYNC);

  // R4: the aligning code is only shown while the lane is ready
  p_align_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == STAT_ALIGN) |-> ready_o);

endmodule

// File: tb/tb_lane_sync_ctrl.sv
`timescale 1ns/1ps
module tb_lane_sync_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bond = 1'b1, ref_ok = 1'b1, unlock = 1'b0, grp = 1'b0;
  logic comma = 1'b0, err = 1'b0, noskew = 1'b0, allr = 1'b0;
  logic [2:0] status_o;
  logic lol_o, ready_o;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur = "R1";

  always #2.5 clk = ~clk;

  lane_sync_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bond_mode_i(bond), .ref_ok_i(ref_ok),
    .pll_unlock_i(unlock), .group_unlock_i(grp), .comma_i(comma),
    .dec_err_i(err), .no_skew_i(noskew), .all_ready_i(allr),
    .status_o(status_o), .lol_o(lol_o), .ready_o(ready_o)
  );

  // behavioural reference: 0 idle, 1 acquiring, 2 aligning, 3 locked
  int m_st = 0, m_acq = 0, m_low = 0, m_run = 0;
  bit blk[$];

  function automatic logic [2:0] m_status();
    if (!bond && unlock) return 3'b101;
    case (m_st)
      0: return 3'b000;
      1: return 3'b011;
      2: return noskew ? 3'b011 : 3'b111;
      default: return 3'b010;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int nst, nerr;
    bit drop;
    if (!rst_n) begin
      m_st = 0; m_acq = 0; m_low = 0; m_run = 0; blk.delete();
    end else begin
      nst = m_st; drop = 0;
      m_low = ref_ok ? 0 : m_low + 1;
      if (m_st == 3 && !comma) begin
        blk.push_back(err);
        m_run = err ? m_run + 1 : 0;
        if (m_run >= 5) drop = 1;
        if (blk.size() == 16) begin
          nerr = 0;
          foreach (blk[i]) nerr += int'(blk[i]);
          if (nerr > 8) drop = 1;
          blk.delete();
        end
      end else begin
        blk.delete(); m_run = 0;
      end
      if (m_low >= 16 || unlock) begin
        nst = 0; m_acq = 0;
      end else begin
        case (m_st)
          0: if (comma) begin nst = 1; m_acq = 1; end
          1: if (comma) begin
               m_acq++;
               if (m_acq == 4) begin nst = 2; m_acq = 0; end
             end else m_acq = 0;
          2: if (!comma && !err && (allr || !bond)) nst = 3;
          default: if (drop || (bond && grp)) nst = 0;
        endcase
      end
      m_st = nst;
    end
  end

  // compare with the reference on every clock, after the edge has settled
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      checks++;
      if (status_o !== m_status() || ready_o !== (m_st == 2) || lol_o !== unlock) begin
        fails++;
        $display("FAIL %s per-cycle: actual st=%b rdy=%b lol=%b expected st=%b rdy=%b lol=%b",
                 cur, status_o, ready_o, lol_o, m_status(), (m_st == 2), unlock);
      end
    end
  end

  task automatic chk(input logic [2:0] es, input logic er, input string tag);
    checks++;
    if (status_o !== es || ready_o !== er) begin
      fails++;
      $display("FAIL %s: actual status=%b ready=%b expected status=%b ready=%b",
               tag, status_o, ready_o, es, er);
    end
  endtask

  task automatic step(input logic c, input logic e);
    comma = c; err = e;
    @(negedge clk);
  endtask

  task automatic go_insync(input logic ar);
    repeat (4) step(1, 0);
    chk(noskew ? 3'b011 : 3'b111, 1'b1, "R4");
    allr = ar;
    step(0, 0);
    allr = 1'b0;
    chk(3'b010, 1'b0, "R5");
  endtask

  task automatic errs(input int n);
    for (int i = 0; i < n; i++) step(0, 1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur = "R1"; chk(3'b000, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    step(0, 0); chk(3'b000, 1'b0, "R1 after reset");

    cur = "R2"; step(1, 0); chk(3'b011, 1'b0, "R2");
    cur = "R3";
    step(1, 0); step(0, 0); chk(3'b011, 1'b0, "R3 reset count at 2");
    step(1, 0); step(1, 0); step(1, 0); step(0, 0); chk(3'b011, 1'b0, "R3 reset count at 3");
    step(1, 0); step(1, 0); step(1, 0); chk(3'b011, 1'b0, "R3 three commas");
    step(1, 0); chk(3'b111, 1'b1, "R3 fourth comma");
    cur = "R4"; noskew = 1'b1; #1; chk(3'b011, 1'b1, "R4 no skew"); noskew = 1'b0;
    cur = "R5";
    step(0, 0); chk(3'b111, 1'b1, "R5 waits for group");
    allr = 1'b1; step(1, 0); chk(3'b111, 1'b1, "R5 comma not data");
    step(0, 1); chk(3'b111, 1'b1, "R5 error not data");
    step(0, 0); allr = 1'b0; chk(3'b010, 1'b0, "R5 locked");

    cur = "R6";
    errs(4); step(0, 0); chk(3'b010, 1'b0, "R6 four errors");
    errs(4); chk(3'b010, 1'b0, "R6 fourth of run");
    errs(1); chk(3'b000, 1'b0, "R6 fifth error");

    cur = "R8"; go_insync(1'b1);
    errs(4); step(1, 0); errs(4); step(0, 0); chk(3'b010, 1'b0, "R8 comma clears");

    cur = "R7"; step(1, 0);
    errs(4); step(0, 0); errs(4); step(0, 0);
    for (int i = 0; i < 6; i++) step(0, 0);
    chk(3'b010, 1'b0, "R7 eight of sixteen");
    errs(4); step(0, 0); errs(4); step(0, 0); errs(1);
    for (int i = 0; i < 4; i++) step(0, 0);
    chk(3'b010, 1'b0, "R7 fifteenth word");
    step(0, 0); chk(3'b000, 1'b0, "R7 nine of sixteen");

    cur = "R9"; go_insync(1'b1);
    unlock = 1'b1; step(0, 0); chk(3'b000, 1'b0, "R9 own unlock");
    checks++;
    if (lol_o !== 1'b1) begin fails++; $display("FAIL R11: actual lol=%b expected lol=1", lol_o); end
    unlock = 1'b0;
    go_insync(1'b1);
    grp = 1'b1; step(0, 0); grp = 1'b0; chk(3'b000, 1'b0, "R9 group unlock bonded");

    cur = "R10"; go_insync(1'b1);
    ref_ok = 1'b0; for (int i = 0; i < 15; i++) step(0, 0);
    chk(3'b010, 1'b0, "R10 fifteen low");
    ref_ok = 1'b1; step(0, 0);
    ref_ok = 1'b0; for (int i = 0; i < 15; i++) step(0, 0);
    chk(3'b010, 1'b0, "R10 counter restarted");
    step(0, 0); chk(3'b000, 1'b0, "R10 sixteenth low");
    ref_ok = 1'b1; step(0, 0);

    cur = "R11"; bond = 1'b0; unlock = 1'b1; step(0, 0);
    chk(3'b101, 1'b0, "R11 independent unlock");
    checks++;
    if (lol_o !== 1'b1) begin fails++; $display("FAIL R11: actual lol=%b expected lol=1", lol_o); end
    unlock = 1'b0; step(0, 0);
    checks++;
    if (lol_o !== 1'b0) begin fails++; $display("FAIL R11: actual lol=%b expected lol=0", lol_o); end

    cur = "R5"; go_insync(1'b0);
    cur = "R9"; grp = 1'b1; step(0, 0); grp = 1'b0; chk(3'b010, 1'b0, "R9 group ignored independent");

    step(0, 0);
    done = 1;
    summary();
    $finish;
  end
endmodule